// File: doc/BRIEF.md
# Parametric Vector Register File

This block is the operand storage of a small vector coprocessor. It keeps a configurable number of vector registers, each a row of 32-bit single-precision element slots, together with two vector accumulators, a small file of 32-bit scalar registers and a byte-count length register. Two vector read ports serve the decode stage. They sample their register numbers and deliver data on the falling clock edge, so operands are ready half a cycle before execution begins.

Results from the execution pipe are not written straight into storage. A result offered on a rising edge is captured in a one-entry holding register, together with the element mask derived from the length register. It is committed to a vector register or an accumulator on the following rising edge. The read ports forward held data that has not yet been committed. A result may instead be a splat, where one scalar register is copied into every element slot under the same mask. The bench supplies the result data. Arithmetic, decode, memory traffic and the host link are outside this block.

Top module: `vecreg_file`

## Requirements
- R1: A synchronous active-high reset clears every vector register, both accumulators, every scalar register and the length register to zero. The read port outputs read zero.
- R2: Each of the two vector read ports samples its register number on the falling clock edge and holds that register's contents on its output until the next falling edge. Element i sits in bits [32*i+31:32*i].
- R3: A result with `res_vld` high at a rising edge is captured, and it is committed to storage at the next rising edge. It is visible through a read port at every falling edge from capture onwards.
- R4: The length register counts bytes. Only elements with index below floor(length/4) are written, and the other elements keep their values. A length of 0 to 3 writes no element.
- R5: A length at or above 4*NUM_ELEM writes every element, including the exact value 4*NUM_ELEM and values beyond it.
- R6: A read at the falling edge between capture and commit returns the held value in the masked element slots and the stored value in the other slots.
- R7: With `res_splat` high, `res_data` is ignored and the scalar register selected by `res_sidx` is copied into every masked element of the destination.
- R8: With `res_to_acc` high, the result goes to accumulator `res_dst[0]` and no vector register changes. Otherwise it goes to vector register `res_dst` and no accumulator changes. The accumulator read port follows the same falling-edge timing and forwarding as the vector read ports.
- R9: A scalar write with `sreg_we` high is stored at the rising edge and appears combinationally on `sreg_rdata` for the selected address.
- R10: `len_we` loads the length register at the rising edge, and `len_rdata` shows its value. A result captured on the same edge as a length load uses the old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; storage on rising edge, read ports on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| len_we | input | 1 | Load the length register |
| len_wdata | input | LEN_W | New length in bytes |
| len_rdata | output | LEN_W | Current length register value |
| sreg_we | input | 1 | Scalar register write enable |
| sreg_waddr | input | $clog2(NUM_SREG) | Scalar write address |
| sreg_wdata | input | 32 | Scalar write data |
| sreg_raddr | input | $clog2(NUM_SREG) | Scalar read address |
| sreg_rdata | output | 32 | Scalar read data |
| res_vld | input | 1 | Result present this cycle |
| res_to_acc | input | 1 | Result targets an accumulator |
| res_dst | input | $clog2(NUM_VREG) | Destination register (bit 0 picks the accumulator) |
| res_splat | input | 1 | Replicate a scalar register instead of using res_data |
| res_sidx | input | $clog2(NUM_SREG) | Scalar source of a splat |
| res_data | input | 32*NUM_ELEM | Result vector |
| rda_addr | input | $clog2(NUM_VREG) | Read port A register number |
| rda_data | output | 32*NUM_ELEM | Read port A data |
| rdb_addr | input | $clog2(NUM_VREG) | Read port B register number |
| rdb_data | output | 32*NUM_ELEM | Read port B data |
| acc_raddr | input | 1 | Accumulator read select |
| acc_rdata | output | 32*NUM_ELEM | Accumulator read data |

## Verification
The bench targets the length boundaries 0, 6, 8, 13, exactly 4*NUM_ELEM and far above it. A design that counted elements instead of bytes, or that clipped the top value wrongly, corrupts neighbouring slots or leaves the last slot stale. It reads each result at the falling edge just after capture, including three back-to-back writes to one register. A design without forwarding, or one that forwards unmasked slots, returns old or foreign data there. Further tests cover a splat fed with misleading result data, accumulator writes aimed at the same index as a vector register, and a length load in the same cycle as a capture. Each of these exposes a wrong source, a leaked write or a mask taken from the new length.

// File: rtl/vrf_pkg.sv
`timescale 1ns/1ps
package vrf_pkg;
    // Width of one single-precision element slot
    localparam int ELEM_W = 32;
    // Bytes per element slot; the length register is measured in bytes
    localparam int ELEM_BYTES = ELEM_W / 8;
    localparam int BYTE_SHIFT = $clog2(ELEM_BYTES);
    // Number of accumulators
    localparam int NUM_ACC = 2;
endpackage

// File: rtl/vrf_lenmask.sv
`timescale 1ns/1ps
module vrf_lenmask import vrf_pkg::*; #(
    parameter int NUM_ELEM = 4,
    parameter int LEN_W    = 8
) (
    input  logic [LEN_W-1:0]    len_i,
    output logic [NUM_ELEM-1:0] mask_o
);
    // Whole elements covered by the byte count (partial elements dropped)
    logic [LEN_W-1:0] whole_elems;
    assign whole_elems = len_i >> BYTE_SHIFT;

    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_slot
        assign mask_o[e] = (32'(whole_elems) > e);
    end
endmodule

// File: rtl/vrf_rdport.sv
`timescale 1ns/1ps
module vrf_rdport import vrf_pkg::*; #(
    parameter int NUM_ELEM = 4,
    parameter int IDX_W    = 3,
    localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    addr_i,
    input  logic [VEC_W-1:0]    stored_i,
    input  logic                hold_vld_i,
    input  logic [IDX_W-1:0]    hold_tag_i,
    input  logic [NUM_ELEM-1:0] hold_mask_i,
    input  logic [VEC_W-1:0]    hold_data_i,
    output logic [VEC_W-1:0]    rdata_o
);
    logic             hit;
    logic [VEC_W-1:0] rdata_d, rdata_q;

    assign hit = hold_vld_i && (hold_tag_i == addr_i);

    // Per-slot merge: pending slots come from the holding register
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_merge
        always_comb begin
            rdata_d[e*ELEM_W +: ELEM_W] = (hit && hold_mask_i[e])
                ? hold_data_i[e*ELEM_W +: ELEM_W]
                : stored_i[e*ELEM_W +: ELEM_W];
        end
    end

    // Operand capture on the falling edge, mid-decode
    always_ff @(negedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/vecreg_file.sv
`timescale 1ns/1ps
module vecreg_file import vrf_pkg::*; #(
    parameter int NUM_VREG = 8,
    parameter int NUM_ELEM = 4,
    parameter int NUM_SREG = 8,
    parameter int LEN_W    = 8,
    localparam int VIDX_W  = $clog2(NUM_VREG),
    localparam int SIDX_W  = $clog2(NUM_SREG),
    localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_wdata,
    output logic [LEN_W-1:0]  len_rdata,
    input  logic              sreg_we,
    input  logic [SIDX_W-1:0] sreg_waddr,
    input  logic [ELEM_W-1:0] sreg_wdata,
    input  logic [SIDX_W-1:0] sreg_raddr,
    output logic [ELEM_W-1:0] sreg_rdata,
    input  logic              res_vld,
    input  logic              res_to_acc,
    input  logic [VIDX_W-1:0] res_dst,
    input  logic              res_splat,
    input  logic [SIDX_W-1:0] res_sidx,
    input  logic [VEC_W-1:0]  res_data,
    input  logic [VIDX_W-1:0] rda_addr,
    output logic [VEC_W-1:0]  rda_data,
    input  logic [VIDX_W-1:0] rdb_addr,
    output logic [VEC_W-1:0]  rdb_data,
    input  logic              acc_raddr,
    output logic [VEC_W-1:0]  acc_rdata
);
    localparam int NUM_RD = 2;

    typedef logic [NUM_ELEM-1:0][ELEM_W-1:0] vec_t;

    typedef struct packed {
        logic                vld;
        logic                acc;
        logic [VIDX_W-1:0]   dst;
        logic [NUM_ELEM-1:0] mask;
        vec_t                data;
    } hold_t;

    typedef struct packed {
        vec_t [NUM_VREG-1:0]                 vreg;
        vec_t [NUM_ACC-1:0]                  acc;
        logic [NUM_SREG-1:0][ELEM_W-1:0]     sreg;
        logic [LEN_W-1:0]                    len;
        hold_t                               hold;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ELEM-1:0] wr_mask;

    vrf_lenmask #(
        .NUM_ELEM (NUM_ELEM),
        .LEN_W    (LEN_W)
    ) u_lenmask (
        .len_i  (st_q.len),
        .mask_o (wr_mask)
    );

    // Next-state computation
    always_comb begin
        st_d = st_q;

        // Commit the held result, slot by slot under its mask
        if (st_q.hold.vld) begin
            for (int e = 0; e < NUM_ELEM; e++) begin
                if (st_q.hold.mask[e]) begin
                    if (st_q.hold.acc)
                        st_d.acc[st_q.hold.dst[0]][e] = st_q.hold.data[e];
                    else
                        st_d.vreg[st_q.hold.dst][e] = st_q.hold.data[e];
                end
            end
        end

        // Capture a new result; mask is taken from the current length
        st_d.hold.vld  = res_vld;
        st_d.hold.acc  = res_to_acc;
        st_d.hold.dst  = res_dst;
        st_d.hold.mask = wr_mask;
        st_d.hold.data = res_splat ? vec_t'({NUM_ELEM{st_q.sreg[res_sidx]}})
                                   : vec_t'(res_data);

        if (sreg_we) st_d.sreg[sreg_waddr] = sreg_wdata;
        if (len_we)  st_d.len = len_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Vector read ports
    logic [NUM_RD-1:0][VIDX_W-1:0] rd_addr;
    logic [NUM_RD-1:0][VEC_W-1:0]  rd_data;

    assign rd_addr = {rdb_addr, rda_addr};

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        vrf_rdport #(
            .NUM_ELEM (NUM_ELEM),
            .IDX_W    (VIDX_W)
        ) u_port (
            .clk         (clk),
            .rst         (rst),
            .addr_i      (rd_addr[p]),
            .stored_i    (st_q.vreg[rd_addr[p]]),
            .hold_vld_i  (st_q.hold.vld && !st_q.hold.acc),
            .hold_tag_i  (st_q.hold.dst),
            .hold_mask_i (st_q.hold.mask),
            .hold_data_i (st_q.hold.data),
            .rdata_o     (rd_data[p])
        );
    end

    assign rda_data = rd_data[0];
    assign rdb_data = rd_data[1];

    // Accumulator read port
    vrf_rdport #(
        .NUM_ELEM (NUM_ELEM),
        .IDX_W    (1)
    ) u_acc_port (
        .clk         (clk),
        .rst         (rst),
        .addr_i      (acc_raddr),
        .stored_i    (st_q.acc[acc_raddr]),
        .hold_vld_i  (st_q.hold.vld && st_q.hold.acc),
        .hold_tag_i  (st_q.hold.dst[0]),
        .hold_mask_i (st_q.hold.mask),
        .hold_data_i (st_q.hold.data),
        .rdata_o     (acc_rdata)
    );

    assign len_rdata  = st_q.len;
    assign sreg_rdata = st_q.sreg[sreg_raddr];
endmodule

// File: rtl/vecreg_file_chk.sv
`timescale 1ns/1ps
module vecreg_file_chk import vrf_pkg::*; #(
    parameter int NUM_VREG = 8,
    parameter int NUM_ELEM = 4,
    parameter int LEN_W    = 8,
    localparam int VIDX_W  = $clog2(NUM_VREG),
    localparam int VEC_W   = NUM_ELEM * ELEM_W
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               len_we,
    input logic [LEN_W-1:0]                   len_wdata,
    input logic [LEN_W-1:0]                   len_rdata,
    input logic                               hold_vld,
    input logic                               hold_acc,
    input logic [VIDX_W-1:0]                  hold_dst,
    input logic [NUM_ELEM-1:0]                hold_mask,
    input logic [VEC_W-1:0]                   hold_data,
    input logic [NUM_VREG-1:0][VEC_W-1:0]     vreg_q,
    input logic [NUM_ACC-1:0][VEC_W-1:0]      acc_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (len_rdata == '0 && vreg_q == '0 && acc_q == '0));

    // R3
    vreg_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_vld && !hold_acc && (&hold_mask))
        |=> vreg_q[$past(hold_dst)] == $past(hold_data));

    // R4
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_vld && hold_mask == '0) |=> ($stable(vreg_q) && $stable(acc_q)));

    // R8
    acc_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_vld && hold_acc) |=> $stable(vreg_q));

    // R8
    acc_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_vld && hold_acc && (&hold_mask))
        |=> acc_q[$past(hold_dst[0])] == $past(hold_data));

    // R10
    len_load_chk: assert property (@(posedge clk) disable iff (rst)
        len_we |=> len_rdata == $past(len_wdata));
endmodule

bind vecreg_file vecreg_file_chk #(
    .NUM_VREG (NUM_VREG),
    .NUM_ELEM (NUM_ELEM),
    .LEN_W    (LEN_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .len_we    (len_we),
    .len_wdata (len_wdata),
    .len_rdata (len_rdata),
    .hold_vld  (st_q.hold.vld),
    .hold_acc  (st_q.hold.acc),
    .hold_dst  (st_q.hold.dst),
    .hold_mask (st_q.hold.mask),
    .hold_data (st_q.hold.data),
    .vreg_q    (st_q.vreg),
    .acc_q     (st_q.acc)
);

// File: tb/vecreg_file_tb.sv
`timescale 1ns/1ps
module vecreg_file_tb;
    localparam int NV = 8;
    localparam int NE = 4;
    localparam int NS = 8;
    localparam int LW = 8;
    localparam int VW = NE * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          len_we = 0;
    logic [LW-1:0] len_wdata = 0;
    logic [LW-1:0] len_rdata;
    logic          sreg_we = 0;
    logic [2:0]    sreg_waddr = 0;
    logic [31:0]   sreg_wdata = 0;
    logic [2:0]    sreg_raddr = 0;
    logic [31:0]   sreg_rdata;
    logic          res_vld = 0;
    logic          res_to_acc = 0;
    logic [2:0]    res_dst = 0;
    logic          res_splat = 0;
    logic [2:0]    res_sidx = 0;
    logic [VW-1:0] res_data = 0;
    logic [2:0]    rda_addr = 0;
    logic [VW-1:0] rda_data;
    logic [2:0]    rdb_addr = 0;
    logic [VW-1:0] rdb_data;
    logic          acc_raddr = 0;
    logic [VW-1:0] acc_rdata;

    always #2 clk = ~clk;

    vecreg_file u_dut (
        .clk(clk), .rst(rst),
        .len_we(len_we), .len_wdata(len_wdata), .len_rdata(len_rdata),
        .sreg_we(sreg_we), .sreg_waddr(sreg_waddr), .sreg_wdata(sreg_wdata),
        .sreg_raddr(sreg_raddr), .sreg_rdata(sreg_rdata),
        .res_vld(res_vld), .res_to_acc(res_to_acc), .res_dst(res_dst),
        .res_splat(res_splat), .res_sidx(res_sidx), .res_data(res_data),
        .rda_addr(rda_addr), .rda_data(rda_data),
        .rdb_addr(rdb_addr), .rdb_data(rdb_data),
        .acc_raddr(acc_raddr), .acc_rdata(acc_rdata)
    );

    // Reference model of architectural state
    logic [31:0]   mv [NV][NE];
    logic [31:0]   ma [2][NE];
    logic [31:0]   ms [NS];
    logic [LW-1:0] mlen;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    function automatic logic [VW-1:0] vec_of_v(int r);
        logic [VW-1:0] v;
        for (int e = 0; e < NE; e++) v[e*32 +: 32] = mv[r][e];
        return v;
    endfunction

    function automatic logic [VW-1:0] vec_of_a(int r);
        logic [VW-1:0] v;
        for (int e = 0; e < NE; e++) v[e*32 +: 32] = ma[r][e];
        return v;
    endfunction

    task automatic chk(string req, logic [VW-1:0] act, logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic set_len(logic [LW-1:0] v);
        len_we = 1; len_wdata = v;
        tick();
        len_we = 0;
        mlen = v;
    endtask

    task automatic set_sreg(int a, logic [31:0] v);
        sreg_we = 1; sreg_waddr = 3'(a); sreg_wdata = v;
        tick();
        sreg_we = 0;
        ms[a] = v;
    endtask

    // Model update at capture, using the length before any same-cycle load
    task automatic model_put(bit acc, int dst, logic [VW-1:0] d, bit splat, int sidx);
        int n;
        n = int'(mlen) / 4;
        for (int e = 0; e < NE; e++) begin
            if (e < n) begin
                if (acc) ma[dst % 2][e] = splat ? ms[sidx] : d[e*32 +: 32];
                else     mv[dst][e]     = splat ? ms[sidx] : d[e*32 +: 32];
            end
        end
    endtask

    task automatic issue(bit acc, int dst, logic [VW-1:0] d, bit splat, int sidx);
        res_vld = 1; res_to_acc = acc; res_dst = 3'(dst);
        res_data = d; res_splat = splat; res_sidx = 3'(sidx);
        tick();
        res_vld = 0;
        model_put(acc, dst, d, splat, sidx);
    endtask

    task automatic issue_len(bit acc, int dst, logic [VW-1:0] d, logic [LW-1:0] nl);
        res_vld = 1; res_to_acc = acc; res_dst = 3'(dst);
        res_data = d; res_splat = 0; res_sidx = 0;
        len_we = 1; len_wdata = nl;
        tick();
        res_vld = 0; len_we = 0;
        model_put(acc, dst, d, 0, 0);
        mlen = nl;
    endtask

    // Drive read numbers, sample just after the falling edge
    task automatic read_cmp(int a, int b, int ac, string req);
        rda_addr = 3'(a); rdb_addr = 3'(b); acc_raddr = 1'(ac);
        @(negedge clk); #1;
        chk({req, " portA"}, rda_data, vec_of_v(a));
        chk({req, " portB"}, rdb_data, vec_of_v(b));
        chk({req, " acc"},   acc_rdata, vec_of_a(ac));
    endtask

    function automatic logic [VW-1:0] pat(logic [7:0] s);
        logic [VW-1:0] v;
        for (int e = 0; e < NE; e++) v[e*32 +: 32] = {s, 8'(e), 8'hA5, ~s};
        return v;
    endfunction

    task automatic t_reset();
        sreg_raddr = 5;
        read_cmp(0, 7, 1, "R1");
        chk("R1 len", VW'(len_rdata), '0);
        chk("R1 sreg", VW'(sreg_rdata), '0);
    endtask

    task automatic t_full();
        set_len(8'd16);
        chk("R10 len load", VW'(len_rdata), VW'(16));
        issue(0, 3, pat(8'h11), 0, 0);
        read_cmp(3, 0, 0, "R6 forward");
        tick();
        read_cmp(0, 3, 0, "R3 commit");
        read_cmp(3, 3, 0, "R2 both ports");
    endtask

    task automatic t_mask();
        set_len(8'd6);
        issue(0, 3, pat(8'h22), 0, 0);
        read_cmp(3, 3, 0, "R6 partial forward");
        tick();
        read_cmp(3, 0, 0, "R4 len6");
        set_len(8'd0);
        issue(0, 3, pat(8'h33), 0, 0);
        tick();
        read_cmp(3, 3, 0, "R4 len0");
        set_len(8'd3);
        issue(0, 3, pat(8'h34), 0, 0);
        tick();
        read_cmp(3, 3, 0, "R4 len3");
        set_len(8'd13);
        issue(0, 4, pat(8'h44), 0, 0);
        tick();
        read_cmp(4, 3, 0, "R4 len13");
    endtask

    task automatic t_over();
        set_len(8'd255);
        issue(0, 5, pat(8'h55), 0, 0);
        tick();
        read_cmp(5, 4, 0, "R5 len255");
        set_len(8'd16);
        issue(0, 4, pat(8'h66), 0, 0);
        tick();
        read_cmp(4, 5, 0, "R5 len16");
    endtask

    task automatic t_splat();
        set_sreg(5, 32'hCAFE_F00D);
        sreg_raddr = 5;
        #0;
        chk("R9 sreg read", VW'(sreg_rdata), VW'(32'hCAFE_F00D));
        set_len(8'd8);
        issue(0, 1, pat(8'h77), 1, 5);
        read_cmp(1, 5, 0, "R7 splat forward");
        tick();
        read_cmp(1, 1, 0, "R7 splat len8");
    endtask

    task automatic t_acc();
        set_len(8'd16);
        issue(1, 1, pat(8'h88), 0, 0);
        read_cmp(1, 0, 1, "R8 acc forward");
        tick();
        read_cmp(1, 0, 1, "R8 acc1 vreg1 untouched");
        set_len(8'd4);
        issue(1, 0, pat(8'h99), 0, 0);
        tick();
        read_cmp(0, 1, 0, "R8 acc0 len4");
    endtask

    task automatic t_b2b();
        set_len(8'd16);
        issue(0, 2, pat(8'hA1), 0, 0);
        issue_len(0, 2, pat(8'hB2), 8'd8);
        issue(0, 2, pat(8'hC3), 0, 0);
        chk("R10 len after same-cycle load", VW'(len_rdata), VW'(8));
        read_cmp(2, 2, 0, "R10 old length mask");
        tick();
        read_cmp(2, 6, 0, "R6 back-to-back");
    endtask

    task automatic t_rand();
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom();
            if (r[3:0] == 0) set_sreg(int'(r[6:4]), $urandom());
            if (r[9:7] == 0) set_len(8'($urandom() % 24));
            issue(r[10], int'(r[13:11]),
                  {$urandom(), $urandom(), $urandom(), $urandom()},
                  r[14], int'(r[17:15]));
            read_cmp(int'(r[20:18]), int'(r[13:11]), int'(r[11]), "R2 random");
            if (r[21]) begin
                tick();
                read_cmp(int'(r[24:22]), int'(r[13:11]), int'(r[25]), "R3 random");
            end
        end
    endtask

    initial begin
        for (int r = 0; r < NV; r++) for (int e = 0; e < NE; e++) mv[r][e] = '0;
        for (int r = 0; r < 2; r++)  for (int e = 0; e < NE; e++) ma[r][e] = '0;
        for (int r = 0; r < NS; r++) ms[r] = '0;
        mlen = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_full();
        t_mask();
        t_over();
        t_splat();
        t_acc();
        t_b2b();
        t_rand();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule